// File: doc/BRIEF.md
# Exception Entry Context Stacker

This block saves the interrupted context when the core accepts an exception. It takes the exception request with its number, the current execution mode, the stack-select bit, both stack pointers and the eight register values to be saved. It then writes those eight words to memory, one word per accepted write. The frame goes on whichever stack the interrupted code was using.

Every push is issued under the rules of the interrupted code. The mode does not change until all eight words are safely written. The protection unit and the stack-limit checker return a fault flag with each write. If a push faults, the remaining pushes are dropped. A derived fault is then reported with its cause, and the original exception number is handed back so it can stay pending.

When all eight words are written, the block emits a completion pulse, records the active exception number, signals the switch to Handler mode on the main stack, and gives back the new stack pointer value to write.

Top module: `exc_stacker`

## Requirements
- R1: After reset, `mem_req`, `busy`, `done`, `enter_handler`, `sp_wb_en` and `flt_valid` are 0, and `active_exc` is 0.
- R2: The frame goes on the process stack (`psp`) when `in_handler` is 0 and `spsel` is 1, and on the main stack (`msp`) otherwise.
- R3: The frame base is the selected stack pointer minus 32. Word k (k = 0..7) is taken from `ctx_words[32k+31:32k]`, in the order R0, R1, R2, R3, R12, LR, return address, status. It is written at base + 4k, in ascending order.
- R4: `mem_req` rises on the clock edge after `exc_req` is seen while idle. One word completes on each edge where `mem_req` and `mem_ready` are both 1. While `mem_ready` is 0, `mem_addr` and `mem_wdata` stay unchanged.
- R5: During stacking, `mem_unpriv` is 1 exactly when the interrupted code was in Thread mode (`in_handler` = 0) with `thread_unpriv` = 1, so the thread's access rules apply to every push.
- R6: A write that completes with `mem_fault` = 1 is the last write of that exception. `mem_req` is 0 from the next cycle until a new exception is accepted.
- R7: One cycle after a faulting write, `flt_valid` pulses for one cycle. The cause is `flt_stkof` when `mem_fault_kind` = 1 (stack limit) and `flt_stkerr` when `mem_fault_kind` = 0 (protection); exactly one of them is 1.
- R8: When a fault is reported, `flt_pend_exc` carries the original exception number. In that case `done`, `enter_handler` and `sp_wb_en` stay 0, and `active_exc` keeps its previous value.
- R9: One cycle after the eighth write completes without a fault, `done`, `enter_handler` and `sp_wb_en` pulse for one cycle. At the same time `active_exc` takes the exception number, `sp_wb_val` equals the frame base, and `sp_wb_psp` shows which stack was used.
- R10: While `busy` is 1, `exc_req` and `exc_num` have no effect on the write sequence or on the reported exception number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req | input | 1 | Exception accepted, start stacking |
| exc_num | input | 9 | Number of the accepted exception |
| in_handler | input | 1 | Core currently in Handler mode |
| spsel | input | 1 | Thread code selected the process stack |
| thread_unpriv | input | 1 | Thread code runs unprivileged |
| msp | input | 32 | Main stack pointer |
| psp | input | 32 | Process stack pointer |
| ctx_words | input | 256 | Eight context words, word k in bits 32k+31:32k |
| mem_req | output | 1 | Write request |
| mem_addr | output | 32 | Write address |
| mem_wdata | output | 32 | Write data |
| mem_unpriv | output | 1 | Write carries unprivileged thread rules |
| mem_ready | input | 1 | Write completes this cycle |
| mem_fault | input | 1 | Completing write was refused |
| mem_fault_kind | input | 1 | 1 = stack limit, 0 = protection |
| busy | output | 1 | Stacking in progress |
| done | output | 1 | Frame complete pulse |
| enter_handler | output | 1 | Switch to Handler mode on main stack |
| active_exc | output | 9 | Active exception number |
| sp_wb_en | output | 1 | Stack pointer write-back strobe |
| sp_wb_psp | output | 1 | Write-back targets process stack |
| sp_wb_val | output | 32 | New stack pointer value |
| flt_valid | output | 1 | Derived fault pulse |
| flt_stkof | output | 1 | Cause: stack limit |
| flt_stkerr | output | 1 | Cause: protection on push |
| flt_pend_exc | output | 9 | Original exception, left pending |

## Verification
The hardest case to reach is a fault on the last push, or on a push that came after several wait cycles. There the abandon path must win over completion at the exact edge where the frame would otherwise finish. The stimulus places the fault at directed indices 0 and 7 and then at random indices, under random ready patterns. It also drives random exception requests while stacking is in progress, so any change they cause to the address sequence or the reported number shows up at the ports.

// File: rtl/exc_stk_pkg.sv
// Package: shared constants and types of the exception context stacker.
// Assumes one frame of eight data words; the order is fixed by the frame layout.
package exc_stk_pkg;
    localparam int FRAME_WORDS = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PUSH = 1'b1
    } stk_state_e;

    typedef enum logic {
        FK_PROT  = 1'b0,
        FK_LIMIT = 1'b1
    } fault_kind_e;
endpackage

// File: rtl/stk_base_sel.sv
// stk_base_sel: chooses the stack in use by the interrupted code and computes
// the frame base below it. Purely combinational.
// Assumes Handler mode always runs on the main stack.
module stk_base_sel #(
    parameter int AW          = 32,
    parameter int FRAME_BYTES = 32
) (
    input  logic          in_handler,
    input  logic          spsel,
    input  logic [AW-1:0] msp,
    input  logic [AW-1:0] psp,
    output logic          use_psp,
    output logic [AW-1:0] base
);
    // Pick the active stack and step down by one frame.
    always_comb begin
        use_psp = !in_handler && spsel;
        base    = (use_psp ? psp : msp) - AW'(FRAME_BYTES);
    end
endmodule

// File: rtl/stk_word_mux.sv
// stk_word_mux: selects one word of the latched context by push index.
// Assumes the packed vector holds word k at bits k*DW upward.
module stk_word_mux #(
    parameter int DW    = 32,
    parameter int NW    = 8,
    parameter int IDX_W = 3
) (
    input  logic [NW*DW-1:0] ctx,
    input  logic [IDX_W-1:0] idx,
    output logic [DW-1:0]    word
);
    logic [DW-1:0] slot [NW];

    // Split the packed context into addressable slots.
    for (genvar g = 0; g < NW; g++) begin : g_slot
        assign slot[g] = ctx[g*DW +: DW];
    end

    // Return the slot addressed by the current push index.
    always_comb word = slot[idx];
endmodule

// File: rtl/stk_ctrl.sv
// stk_ctrl: push sequencer. It latches the context on acceptance, writes one
// word per completed handshake, abandons on a fault and reports the outcome.
// Assumes mem_fault and mem_fault_kind are valid only together with mem_ready.
module stk_ctrl
    import exc_stk_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int EXC_W = 9,
    parameter int NW    = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_req,
    input  logic [EXC_W-1:0] exc_num,
    input  logic             in_handler,
    input  logic             thread_unpriv,
    input  logic             use_psp,
    input  logic [AW-1:0]    base,
    input  logic [NW*DW-1:0] ctx_in,
    input  logic             mem_ready,
    input  logic             mem_fault,
    input  logic             mem_fault_kind,
    output logic [NW*DW-1:0] ctx_q,
    output logic [IDX_W-1:0] idx_q,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_unpriv,
    output logic             busy,
    output logic             done,
    output logic             enter_handler,
    output logic [EXC_W-1:0] active_exc,
    output logic             sp_wb_en,
    output logic             sp_wb_psp,
    output logic [AW-1:0]    sp_wb_val,
    output logic             flt_valid,
    output logic             flt_stkof,
    output logic             flt_stkerr,
    output logic [EXC_W-1:0] flt_pend_exc
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NW - 1);
    localparam int               WBYTES   = DW / 8;

    stk_state_e       state_q;
    logic [AW-1:0]    base_q;
    logic [EXC_W-1:0] num_q;
    logic             psp_q;
    logic             unpriv_q;
    logic             hs;

    // Handshake: a push completes this cycle.
    always_comb hs = (state_q == ST_PUSH) && mem_ready;

    // Sequencer state, frame capture and outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            idx_q         <= '0;
            base_q        <= '0;
            num_q         <= '0;
            psp_q         <= 1'b0;
            unpriv_q      <= 1'b0;
            ctx_q         <= '0;
            done          <= 1'b0;
            flt_valid     <= 1'b0;
            flt_stkof     <= 1'b0;
            flt_stkerr    <= 1'b0;
            active_exc    <= '0;
        end else begin
            done       <= 1'b0;
            flt_valid  <= 1'b0;
            flt_stkof  <= 1'b0;
            flt_stkerr <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (exc_req) begin
                        state_q  <= ST_PUSH;
                        idx_q    <= '0;
                        base_q   <= base;
                        num_q    <= exc_num;
                        psp_q    <= use_psp;
                        unpriv_q <= !in_handler && thread_unpriv;
                        ctx_q    <= ctx_in;
                    end
                end
                ST_PUSH: begin
                    if (hs) begin
                        if (mem_fault) begin
                            state_q    <= ST_IDLE;
                            flt_valid  <= 1'b1;
                            flt_stkof  <= (mem_fault_kind == FK_LIMIT);
                            flt_stkerr <= (mem_fault_kind == FK_PROT);
                        end else if (idx_q == LAST_IDX) begin
                            state_q    <= ST_IDLE;
                            done       <= 1'b1;
                            active_exc <= num_q;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory-side request fields and outcome views of the latched frame.
    always_comb begin
        busy          = (state_q == ST_PUSH);
        mem_req       = busy;
        mem_addr      = base_q + AW'(idx_q) * AW'(WBYTES);
        mem_unpriv    = busy && unpriv_q;
        enter_handler = done;
        sp_wb_en      = done;
        sp_wb_psp     = psp_q;
        sp_wb_val     = base_q;
        flt_pend_exc  = num_q;
    end
endmodule

// File: rtl/exc_stacker.sv
// exc_stacker: top of the exception entry context stacker. Selects the stack,
// sequences the eight pushes under the interrupted code's rules and reports
// completion or a derived fault.
// Assumes the memory side reports each write's fault with its ready.
module exc_stacker
    import exc_stk_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int EXC_W = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   exc_req,
    input  logic [EXC_W-1:0]       exc_num,
    input  logic                   in_handler,
    input  logic                   spsel,
    input  logic                   thread_unpriv,
    input  logic [AW-1:0]          msp,
    input  logic [AW-1:0]          psp,
    input  logic [FRAME_WORDS*DW-1:0] ctx_words,
    output logic                   mem_req,
    output logic [AW-1:0]          mem_addr,
    output logic [DW-1:0]          mem_wdata,
    output logic                   mem_unpriv,
    input  logic                   mem_ready,
    input  logic                   mem_fault,
    input  logic                   mem_fault_kind,
    output logic                   busy,
    output logic                   done,
    output logic                   enter_handler,
    output logic [EXC_W-1:0]       active_exc,
    output logic                   sp_wb_en,
    output logic                   sp_wb_psp,
    output logic [AW-1:0]          sp_wb_val,
    output logic                   flt_valid,
    output logic                   flt_stkof,
    output logic                   flt_stkerr,
    output logic [EXC_W-1:0]       flt_pend_exc
);
    localparam int NW          = FRAME_WORDS;
    localparam int IDX_W       = $clog2(NW);
    localparam int FRAME_BYTES = NW * (DW / 8);

    logic                 use_psp;
    logic [AW-1:0]        base;
    logic [NW*DW-1:0]     ctx_q;
    logic [IDX_W-1:0]     idx_q;

    stk_base_sel #(.AW(AW), .FRAME_BYTES(FRAME_BYTES)) u_base (
        .in_handler (in_handler),
        .spsel      (spsel),
        .msp        (msp),
        .psp        (psp),
        .use_psp    (use_psp),
        .base       (base)
    );

    stk_ctrl #(.AW(AW), .DW(DW), .EXC_W(EXC_W), .NW(NW), .IDX_W(IDX_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .exc_req        (exc_req),
        .exc_num        (exc_num),
        .in_handler     (in_handler),
        .thread_unpriv  (thread_unpriv),
        .use_psp        (use_psp),
        .base           (base),
        .ctx_in         (ctx_words),
        .mem_ready      (mem_ready),
        .mem_fault      (mem_fault),
        .mem_fault_kind (mem_fault_kind),
        .ctx_q          (ctx_q),
        .idx_q          (idx_q),
        .mem_req        (mem_req),
        .mem_addr       (mem_addr),
        .mem_unpriv     (mem_unpriv),
        .busy           (busy),
        .done           (done),
        .enter_handler  (enter_handler),
        .active_exc     (active_exc),
        .sp_wb_en       (sp_wb_en),
        .sp_wb_psp      (sp_wb_psp),
        .sp_wb_val      (sp_wb_val),
        .flt_valid      (flt_valid),
        .flt_stkof      (flt_stkof),
        .flt_stkerr     (flt_stkerr),
        .flt_pend_exc   (flt_pend_exc)
    );

    stk_word_mux #(.DW(DW), .NW(NW), .IDX_W(IDX_W)) u_mux (
        .ctx  (ctx_q),
        .idx  (idx_q),
        .word (mem_wdata)
    );
endmodule

// File: rtl/exc_stacker_chk.sv
// exc_stacker_chk: temporal properties of the stacker, checked at its ports.
// Assumes it is bound to every exc_stacker instance.
module exc_stacker_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_ready,
    input logic          mem_fault,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          done,
    input logic          flt_valid,
    input logic          flt_stkof,
    input logic          flt_stkerr
);
    // Write fields hold while the memory side stalls.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

    // A clean completed push that is not the last moves up one word.
    p_ascend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_fault) |=> (!mem_req || mem_addr == $past(mem_addr) + AW'(DW / 8)));

    // A faulting push ends the sequence.
    p_abandon_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_fault) |=> !mem_req);

    // A faulting push is reported as a derived fault, not a completion.
    p_derived_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_fault) |=> (flt_valid && !done));

    // Exactly one cause accompanies a derived fault.
    p_one_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> ($countones({flt_stkof, flt_stkerr}) == 1));

    // Completion and fault never coincide.
    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && flt_valid));
endmodule

bind exc_stacker exc_stacker_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_ready  (mem_ready),
    .mem_fault  (mem_fault),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .done       (done),
    .flt_valid  (flt_valid),
    .flt_stkof  (flt_stkof),
    .flt_stkerr (flt_stkerr)
);

// File: tb/exc_stacker_tb.sv
// Bench for exc_stacker: directed corners plus seeded random exceptions.
module exc_stacker_tb;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          exc_req = 1'b0;
    logic [8:0]    exc_num = '0;
    logic          in_handler = 1'b0;
    logic          spsel = 1'b0;
    logic          thread_unpriv = 1'b0;
    logic [31:0]   msp = '0;
    logic [31:0]   psp = '0;
    logic [255:0]  ctx_words = '0;
    logic          mem_req;
    logic [31:0]   mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_unpriv;
    logic          mem_ready = 1'b0;
    logic          mem_fault = 1'b0;
    logic          mem_fault_kind = 1'b0;
    logic          busy, done, enter_handler, sp_wb_en, sp_wb_psp;
    logic [8:0]    active_exc, flt_pend_exc;
    logic [31:0]   sp_wb_val;
    logic          flt_valid, flt_stkof, flt_stkerr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [8:0] prev_active = '0;

    always #2.5 clk = ~clk;

    exc_stacker u_dut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_num(exc_num),
        .in_handler(in_handler), .spsel(spsel), .thread_unpriv(thread_unpriv),
        .msp(msp), .psp(psp), .ctx_words(ctx_words),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_unpriv(mem_unpriv), .mem_ready(mem_ready), .mem_fault(mem_fault),
        .mem_fault_kind(mem_fault_kind), .busy(busy), .done(done),
        .enter_handler(enter_handler), .active_exc(active_exc),
        .sp_wb_en(sp_wb_en), .sp_wb_psp(sp_wb_psp), .sp_wb_val(sp_wb_val),
        .flt_valid(flt_valid), .flt_stkof(flt_stkof), .flt_stkerr(flt_stkerr),
        .flt_pend_exc(flt_pend_exc)
    );

    function automatic bit exp_use_psp(bit h, bit s);
        return !h && s;
    endfunction

    function automatic logic [31:0] exp_base(logic [31:0] m, logic [31:0] p, bit h, bit s);
        return (exp_use_psp(h, s) ? p : m) - 32'd32;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic run_exc(logic [31:0] m, logic [31:0] p, bit h, bit s, bit u,
                           int fault_idx, bit fkind, int ready_pct, bit noise);
        logic [255:0] words;
        logic [8:0]   num;
        logic [31:0]  base;
        int k = 0;
        int guard = 0;
        bit fin = 1'b0;
        bit faulted = 1'b0;
        for (int w = 0; w < 8; w++) words[w*32 +: 32] = $urandom;
        num = 9'(1 + ($urandom % 511));
        base = exp_base(m, p, h, s);
        msp = m; psp = p; in_handler = h; spsel = s; thread_unpriv = u;
        ctx_words = words; exc_num = num; exc_req = 1'b1;
        @(negedge clk);
        exc_req = 1'b0;
        chk(mem_req == 1'b1, "R4 req after accept", 32'(mem_req), 32'd1);
        while (!fin && guard < 2000) begin
            guard++;
            chk(mem_req && busy, "R10 busy during push", 32'(busy), 32'd1);
            chk(mem_addr == base + 32'(4 * k), "R3 R2 push address", mem_addr, base + 32'(4 * k));
            chk(mem_wdata == words[k*32 +: 32], "R3 push data", mem_wdata, words[k*32 +: 32]);
            chk(mem_unpriv == (!h && u), "R5 thread rules", 32'(mem_unpriv), 32'(!h && u));
            if (($urandom % 100) < ready_pct) begin
                mem_ready = 1'b1;
                if (k == fault_idx) begin
                    mem_fault = 1'b1;
                    mem_fault_kind = fkind;
                    faulted = 1'b1;
                    fin = 1'b1;
                end else begin
                    mem_fault = 1'b0;
                    mem_fault_kind = $urandom % 2;
                    if (k == 7) fin = 1'b1;
                end
                k++;
            end else begin
                mem_ready = 1'b0;
                mem_fault = $urandom % 2;
            end
            if (noise && !fin) begin
                exc_req = $urandom % 2;
                exc_num = 9'($urandom);
                msp = $urandom; psp = $urandom;
            end else begin
                exc_req = 1'b0;
            end
            @(negedge clk);
            mem_ready = 1'b0;
            mem_fault = 1'b0;
        end
        if (!fin) chk(1'b0, "R4 push sequence stalled", 32'(k), 32'd8);
        if (faulted) begin
            chk(flt_valid == 1'b1, "R7 fault pulse", 32'(flt_valid), 32'd1);
            chk(flt_stkof == fkind, "R7 limit cause", 32'(flt_stkof), 32'(fkind));
            chk(flt_stkerr == !fkind, "R7 protection cause", 32'(flt_stkerr), 32'(!fkind));
            chk(flt_pend_exc == num, "R8 pending original", 32'(flt_pend_exc), 32'(num));
            chk(!done && !enter_handler && !sp_wb_en, "R8 no completion", 32'(done), 32'd0);
            chk(active_exc == prev_active, "R8 active kept", 32'(active_exc), 32'(prev_active));
            chk(mem_req == 1'b0, "R6 abandon", 32'(mem_req), 32'd0);
        end else begin
            chk(done && enter_handler && sp_wb_en, "R9 completion pulse", 32'(done), 32'd1);
            chk(active_exc == num, "R9 R10 active number", 32'(active_exc), 32'(num));
            chk(sp_wb_val == base, "R9 new stack pointer", sp_wb_val, base);
            chk(sp_wb_psp == exp_use_psp(h, s), "R9 R2 stack written back", 32'(sp_wb_psp), 32'(exp_use_psp(h, s)));
            chk(flt_valid == 1'b0, "R9 no fault", 32'(flt_valid), 32'd0);
            prev_active = num;
        end
        @(negedge clk);
        chk(!done && !flt_valid && !sp_wb_en, "R9 R7 single pulse", 32'(done | flt_valid), 32'd0);
        chk(mem_req == 1'b0 && busy == 1'b0, "R6 idle after", 32'(mem_req), 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0005_eed1));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req && !busy && !done && !flt_valid, "R1 reset outputs", 32'(mem_req | busy), 32'd0);
        chk(!enter_handler && !sp_wb_en && active_exc == '0, "R1 reset state", 32'(active_exc), 32'd0);

        run_exc(32'h2000_1000, 32'h2000_0F80, 1'b0, 1'b1, 1'b1, -1, 1'b0, 100, 1'b0);
        run_exc(32'h2000_1000, 32'h2000_0F80, 1'b1, 1'b1, 1'b0, -1, 1'b0, 100, 1'b0);
        run_exc(32'h2000_1000, 32'h2000_0F80, 1'b0, 1'b0, 1'b1, -1, 1'b0, 40, 1'b1);
        run_exc(32'h2000_1000, 32'h2000_0F80, 1'b0, 1'b1, 1'b1, 0, 1'b1, 100, 1'b0);
        run_exc(32'h2000_1000, 32'h2000_0F80, 1'b0, 1'b1, 1'b1, 7, 1'b0, 50, 1'b1);
        run_exc(32'h0000_0010, 32'h0000_0008, 1'b1, 1'b0, 1'b1, -1, 1'b0, 70, 1'b0);

        for (int i = 0; i < 40; i++) begin
            run_exc($urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC,
                    1'($urandom), 1'($urandom), 1'($urandom),
                    (($urandom % 3) == 0) ? int'($urandom % 8) : -1,
                    1'($urandom), 30 + int'($urandom % 71), 1'($urandom));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule